// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array with Output Macrocells

The block models a small field-configurable logic device. A programmable AND plane forms product terms from every array signal, in both true and inverted form. A fixed OR plane collects each macrocell's product terms into one sum. Eight output macrocells then turn those sums into pin behaviour.

Each macrocell takes one of four roles from two configuration bits: registered output, combinational output, combinational bidirectional, or pure input. Three global bits complete the configuration:
- one bit selects whether the two dual-purpose pins work as the shared clock and shared output enable, or as plain logic inputs;
- two bits steer the feedback selector, which returns either a macrocell's own pin or the pin of its mirror-image partner.

Each pin is modelled as separate in, out and enable signals. The whole configuration arrives as flat vectors that hold steady during operation.

Top module: `pal_logic_array`

## Requirements
- R1: A product term whose fuses are all zero (no connection) evaluates to 1.
- R2: A product term that connects both the true and the inverted column of the same signal evaluates to 0.
- R3: Array signals are numbered with the data inputs first (0..N_DIN-1), then the two auxiliary inputs, then one feedback signal per macrocell. Signal s has its true column at 2s and its inverted column at 2s+1. Product term t of cell c occupies fuse bits starting at (c*N_PT+t)*N_COL, and a fuse bit of 1 means connected. A cell's sum is the OR of its product terms.
- R4: When a cell's polarity bit is 1, the cell inverts its sum before the output and before the register.
- R5: Role code 0 (registered) captures the polarity-adjusted sum on the rising clock edge and drives the register value. Its enable is 1 only while sync mode is on and oe_ni is low.
- R6: A registered cell feeds its register value, not its pin, back into the array.
- R7: Role code 1 (combinational output) always enables its driver and ORs all N_PT terms.
- R8: Role code 2 (bidirectional) uses product term 0 as its driver enable. Only terms 1..N_PT-1 form its sum.
- R9: Role code 3 (input) never enables its driver, and it feeds its pin level into the array.
- R10: With cfg_sync_i at 1, the array reads both auxiliary signals as 0. With cfg_sync_i at 0, the array reads the aux_i levels, and registered cells keep their drivers off.
- R11: For a non-registered cell k, the feedback is io_i[k] when its selector is 0 and io_i[N_CELL-1-k] when it is 1. Cells 0 and N_CELL-1 take the selector from cfg_edge_i; all other cells take it from cfg_adj_i.
- R12: Asserting rst_ni low clears every register to 0 at once, whatever the clock is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared register clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the registers |
| din_i | input | N_DIN | Dedicated data inputs to the array |
| aux_i | input | 2 | Dual-purpose pin levels, used as array inputs when sync mode is off |
| oe_ni | input | 1 | Shared active-low output enable for registered cells |
| io_i | input | N_CELL | Level seen on each macrocell pin |
| io_o | output | N_CELL | Value each macrocell drives |
| io_oe_o | output | N_CELL | Driver enable of each macrocell |
| fuse_i | input | N_CELL*N_PT*2*(N_DIN+2+N_CELL) | AND-plane connection map |
| role_i | input | 2*N_CELL | Role code per cell, cell k at bits 2k+1:2k |
| pol_i | input | N_CELL | Output inversion per cell |
| cfg_sync_i | input | 1 | 1: dual-purpose pins are clock and enable |
| cfg_adj_i | input | 1 | Feedback selector for inner cells |
| cfg_edge_i | input | 1 | Feedback selector for the two outer cells |

## Verification
Two functions meet at a single edge: the register capture, and the feedback that recomputes that register's next sum. The bench builds a registered cell whose only product term is the inverse of its own feedback. Each edge must then flip the output exactly once, and the bench checks the value after every edge against a strict alternation. During one of those edges the shared enable is raised. The bench then checks two things: the driver turns off at once, and the register has still advanced when the enable returns.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [1:0] {
    ROLE_REG   = 2'd0,
    ROLE_COMB  = 2'd1,
    ROLE_BIDIR = 2'd2,
    ROLE_INPUT = 2'd3
  } role_e;
endpackage

// File: rtl/pal_lit_bus.sv
module pal_lit_bus #(
  parameter int unsigned N_DIN  = 8,
  parameter int unsigned N_CELL = 8,
  localparam int unsigned N_SIG = N_DIN + 2 + N_CELL,
  localparam int unsigned N_COL = 2 * N_SIG
) (
  input  logic [N_DIN-1:0]  din_i,
  input  logic [1:0]        aux_i,
  input  logic              sync_i,
  input  logic [N_CELL-1:0] fb_i,
  output logic [N_COL-1:0]  lit_o
);
  logic [N_SIG-1:0] sig;

  // in sync mode the dual-purpose pins are clock/enable, not logic
  assign sig = {fb_i, (sync_i ? 2'b00 : aux_i), din_i};

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit_o[2*s]   = sig[s];
    assign lit_o[2*s+1] = ~sig[s];
  end
endmodule

// File: rtl/pal_and_term.sv
module pal_and_term #(
  parameter int unsigned N_COL = 36
) (
  input  logic [N_COL-1:0] lit_i,
  input  logic [N_COL-1:0] fuse_i,
  output logic             pt_o
);
  // unconnected columns read as 1; an empty term is therefore 1
  assign pt_o = &(lit_i | ~fuse_i);
endmodule

// File: rtl/pal_cell.sv
module pal_cell
  import pal_pkg::*;
#(
  parameter int unsigned N_COL = 36,
  parameter int unsigned N_PT  = 8,
  localparam int unsigned N_FC = N_PT * N_COL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_COL-1:0] lit_i,
  input  logic [N_FC-1:0]  fuse_i,
  input  role_e            role_i,
  input  logic             pol_i,
  input  logic             sync_i,
  input  logic             oe_ni,
  input  logic             sel_i,
  input  logic             pin_i,
  input  logic             pin_mirror_i,
  output logic             out_o,
  output logic             oe_o,
  output logic             fb_o
);
  logic [N_PT-1:0] pt;
  logic sum, d, q;

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    pal_and_term #(.N_COL(N_COL)) u_term (
      .lit_i (lit_i),
      .fuse_i(fuse_i[t*N_COL +: N_COL]),
      .pt_o  (pt[t])
    );
  end

  // term 0 is reserved for the enable in bidirectional role
  always_comb begin
    if (role_i == ROLE_BIDIR) sum = |pt[N_PT-1:1];
    else                      sum = |pt;
  end

  assign d = sum ^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= 1'b0;
    else         q <= d;
  end

  always_comb begin
    unique case (role_i)
      ROLE_REG:   oe_o = sync_i & ~oe_ni;
      ROLE_COMB:  oe_o = 1'b1;
      ROLE_BIDIR: oe_o = pt[0];
      default:    oe_o = 1'b0;
    endcase
  end

  assign out_o = (role_i == ROLE_REG) ? q : d;
  assign fb_o  = (role_i == ROLE_REG) ? q : (sel_i ? pin_mirror_i : pin_i);
endmodule

// File: rtl/pal_logic_array.sv
module pal_logic_array
  import pal_pkg::*;
#(
  parameter int unsigned N_DIN  = 8,
  parameter int unsigned N_CELL = 8,
  parameter int unsigned N_PT   = 8,
  localparam int unsigned N_COL  = 2 * (N_DIN + 2 + N_CELL),
  localparam int unsigned N_FC   = N_PT * N_COL,
  localparam int unsigned N_FUSE = N_CELL * N_FC
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_DIN-1:0]    din_i,
  input  logic [1:0]          aux_i,
  input  logic                oe_ni,
  input  logic [N_CELL-1:0]   io_i,
  output logic [N_CELL-1:0]   io_o,
  output logic [N_CELL-1:0]   io_oe_o,
  input  logic [N_FUSE-1:0]   fuse_i,
  input  logic [2*N_CELL-1:0] role_i,
  input  logic [N_CELL-1:0]   pol_i,
  input  logic                cfg_sync_i,
  input  logic                cfg_adj_i,
  input  logic                cfg_edge_i
);
  logic [N_CELL-1:0] fb_w;
  logic [N_COL-1:0]  lit_w;

  pal_lit_bus #(.N_DIN(N_DIN), .N_CELL(N_CELL)) u_lit (
    .din_i (din_i),
    .aux_i (aux_i),
    .sync_i(cfg_sync_i),
    .fb_i  (fb_w),
    .lit_o (lit_w)
  );

  for (genvar k = 0; k < N_CELL; k++) begin : g_cell
    localparam bit IS_EDGE = (k == 0) || (k == N_CELL - 1);
    role_e role_k;
    logic  sel_k;

    assign role_k = role_e'(role_i[2*k +: 2]);
    if (IS_EDGE) begin : g_edge
      assign sel_k = cfg_edge_i;
    end else begin : g_inner
      assign sel_k = cfg_adj_i;
    end

    pal_cell #(.N_COL(N_COL), .N_PT(N_PT)) u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lit_i       (lit_w),
      .fuse_i      (fuse_i[k*N_FC +: N_FC]),
      .role_i      (role_k),
      .pol_i       (pol_i[k]),
      .sync_i      (cfg_sync_i),
      .oe_ni       (oe_ni),
      .sel_i       (sel_k),
      .pin_i       (io_i[k]),
      .pin_mirror_i(io_i[N_CELL-1-k]),
      .out_o       (io_o[k]),
      .oe_o        (io_oe_o[k]),
      .fb_o        (fb_w[k])
    );

    // R9
    input_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_k == ROLE_INPUT) |-> !io_oe_o[k]);
    // R7
    comb_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_k == ROLE_COMB) |-> io_oe_o[k]);
    // R10
    async_reg_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_k == ROLE_REG && !cfg_sync_i) |-> !io_oe_o[k]);
    // R6
    reg_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_k == ROLE_REG) |-> (fb_w[k] == io_o[k]));
    // R11
    pin_fb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (role_k != ROLE_REG && io_i[k] == io_i[N_CELL-1-k]) |-> (fb_w[k] == io_i[k]));
  end
endmodule

// File: tb/pal_logic_array_test.sv
`timescale 1ns/1ps
module pal_logic_array_test;
  localparam int N_DIN = 8, N_CELL = 8, N_PT = 8;
  localparam int N_COL = 2 * (N_DIN + 2 + N_CELL);
  localparam int N_FUSE = N_CELL * N_PT * N_COL;
  localparam int SIG_AUX = N_DIN, SIG_FB = N_DIN + 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_DIN-1:0] din;
  logic [1:0] aux;
  logic oe_n;
  logic [N_CELL-1:0] io_in, io_out, io_oe;
  logic [N_FUSE-1:0] fuse;
  logic [2*N_CELL-1:0] role;
  logic [N_CELL-1:0] pol;
  logic sync, adj, edg;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pal_logic_array #(.N_DIN(N_DIN), .N_CELL(N_CELL), .N_PT(N_PT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .aux_i(aux), .oe_ni(oe_n),
    .io_i(io_in), .io_o(io_out), .io_oe_o(io_oe), .fuse_i(fuse),
    .role_i(role), .pol_i(pol), .cfg_sync_i(sync), .cfg_adj_i(adj),
    .cfg_edge_i(edg)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic conn(input int c, input int t, input int s, input int inv);
    fuse[(c*N_PT+t)*N_COL + 2*s + inv] = 1'b1;
  endtask

  task automatic kill_rest(input int c, input int from);
    for (int t = from; t < N_PT; t++) begin
      conn(c, t, 0, 0);
      conn(c, t, 0, 1);
    end
  endtask

  task automatic clear_cell(input int c);
    fuse[c*N_PT*N_COL +: N_PT*N_COL] = '0;
  endtask

  task automatic set_role(input int c, input logic [1:0] r);
    role[2*c +: 2] = r;
  endtask

  task automatic defaults();
    fuse = '0; role = '1; pol = '0; sync = 1'b1; adj = 1'b0; edg = 1'b0;
    oe_n = 1'b0; din = '0; aux = '0; io_in = '0;
  endtask

  task automatic t_terms();
    defaults();
    set_role(1, 2'd1);
    kill_rest(1, 1);
    #1 chk("R1 empty term", io_out[1], 1'b1);
    chk("R7 comb enable", io_oe[1], 1'b1);
    conn(1, 0, 3, 0); conn(1, 0, 3, 1);
    din[3] = 1'b1;
    #1 chk("R2 contradictory term", io_out[1], 1'b0);
    clear_cell(1);
    conn(1, 0, 0, 0); conn(1, 0, 1, 1);
    conn(1, 1, 2, 0);
    kill_rest(1, 2);
    for (int v = 0; v < 8; v++) begin
      din[2:0] = 3'(v);
      #1 chk("R3 sum of products", io_out[1], (din[0] & ~din[1]) | din[2]);
    end
    pol[1] = 1'b1;
    din[2:0] = 3'b001;
    #1 chk("R4 inverted sum", io_out[1], 1'b0);
    din[2:0] = 3'b010;
    #1 chk("R4 inverted sum", io_out[1], 1'b1);
  endtask

  task automatic t_bidir();
    defaults();
    set_role(2, 2'd2);
    conn(2, 0, 3, 0);
    conn(2, 1, 4, 0);
    kill_rest(2, 2);
    din[3] = 1'b0; din[4] = 1'b1;
    #1 chk("R8 enable off", io_oe[2], 1'b0);
    din[3] = 1'b1;
    #1 chk("R8 enable on", io_oe[2], 1'b1);
    chk("R8 data", io_out[2], 1'b1);
    din[4] = 1'b0;
    #1 chk("R8 term0 outside sum", io_out[2], 1'b0);
  endtask

  task automatic t_input_fb();
    defaults();
    set_role(4, 2'd1);
    conn(4, 0, SIG_FB + 3, 0);
    kill_rest(4, 1);
    io_in[3] = 1'b1;
    #1 chk("R9 input driver off", io_oe[3], 1'b0);
    chk("R9 pin into array", io_out[4], 1'b1);
    io_in[3] = 1'b0;
    #1 chk("R9 pin into array", io_out[4], 1'b0);
    io_in[4] = 1'b1;
    adj = 1'b1;
    #1 chk("R11 inner mirror select", io_out[4], 1'b1);
    adj = 1'b0;
    #1 chk("R11 inner own pin", io_out[4], 1'b0);
    set_role(6, 2'd1);
    conn(6, 0, SIG_FB + 0, 0);
    kill_rest(6, 1);
    io_in[0] = 1'b0; io_in[7] = 1'b1;
    adj = 1'b1; edg = 1'b0;
    #1 chk("R11 edge ignores inner bit", io_out[6], 1'b0);
    adj = 1'b0; edg = 1'b1;
    #1 chk("R11 edge mirror select", io_out[6], 1'b1);
  endtask

  task automatic t_aux();
    defaults();
    set_role(5, 2'd1);
    conn(5, 0, SIG_AUX + 0, 0);
    kill_rest(5, 1);
    aux = 2'b01;
    #1 chk("R10 aux masked in sync", io_out[5], 1'b0);
    sync = 1'b0;
    #1 chk("R10 aux read in async", io_out[5], 1'b1);
  endtask

  task automatic t_register();
    defaults();
    set_role(0, 2'd0);
    conn(0, 0, SIG_FB + 0, 1);
    kill_rest(0, 1);
    @(negedge clk) rst_ni = 1'b0;
    #1 chk("R12 reset clears", io_out[0], 1'b0);
    chk("R5 enable with oe low", io_oe[0], 1'b1);
    @(negedge clk) rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk) #1 chk("R6 toggle from feedback", io_out[0], (i % 2 == 0));
    end
    @(negedge clk) oe_n = 1'b1;
    #1 chk("R5 shared enable off", io_oe[0], 1'b0);
    @(posedge clk) #1;
    @(negedge clk) oe_n = 1'b0;
    #1 chk("R5 register ran while off", io_out[0], 1'b0);
    chk("R5 enable back", io_oe[0], 1'b1);
    sync = 1'b0;
    #1 chk("R10 registered off in async", io_oe[0], 1'b0);
    sync = 1'b1;
    clear_cell(0);
    conn(0, 0, 5, 0);
    kill_rest(0, 1);
    @(negedge clk) din[5] = 1'b1;
    #1 chk("R5 holds until edge", io_out[0], 1'b0);
    @(posedge clk) #1 chk("R5 captures", io_out[0], 1'b1);
    @(negedge clk) din[5] = 1'b0;
    @(posedge clk) #1 chk("R5 captures", io_out[0], 1'b0);
    @(negedge clk) din[5] = 1'b1;
    @(posedge clk) #1;
    @(negedge clk) rst_ni = 1'b0;
    #1 chk("R12 async clear", io_out[0], 1'b0);
    @(negedge clk) rst_ni = 1'b1;
  endtask

  initial begin
    defaults();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_terms();
    t_bidir();
    t_input_fb();
    t_aux();
    t_register();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule